// File: doc/BRIEF.md
# Northbound Read-Return Frame Multiplexer

This block assembles the northbound frame stream of one module in a daisy chain of buffered memory modules. Two sources feed it. The first is read completions from the local DRAM side: 576 bits each, 64 data bytes and 8 check bytes. The second is whole frames forwarded from the module further down the chain. Every frame slot lasts 12 unit intervals and carries 168 bits across 14 lanes. The block emits exactly one frame per slot, so the slot rate follows the DRAM command clock at the fixed 6:1 lane-to-command ratio with double-data-rate lanes.

Forwarded frames pass through unchanged. A 4-entry queue holds them while a local completion is being sent. A local completion is cut into four 144-bit payloads. Each payload gets a type tag, a sequence number and a check field, and the four frames are sent in back-to-back slots. When neither source has anything ready, the block sends an idle frame. The lanes are modelled as one parallel 14-bit vector per unit interval, and the block's clock is the unit-interval clock.

Top module: `nb_frame_mux`

## Requirements
- R1: While reset is held and right after it, `slot_start` is 1, `nb_lanes` carries the all-zero idle frame and `loc_ready` is 1.
- R2: `slot_start` is high for one cycle in every 12. The frame shown during a slot is chosen in the last cycle of the slot before it.
- R3: In unit interval u of a slot (u = 0 is the `slot_start` cycle), lane l carries frame bit u*14+l. So lane 0 carries payload bit 0 in the first unit interval.
- R4: Frame layout is as follows. Bits 143:0 hold the payload. Bits 145:144 hold the sequence number. Bits 147:146 hold the type: 00 means idle and 01 means local data. Check bit j (frame bit 148+j, j = 0..19) is the XOR of every bit i of frame bits 147:0 with i mod 20 = j.
- R5: A slot with no queued forwarded frame, no pending completion and no burst in progress carries the idle frame. Its payload, tag and check are all zero.
- R6: An accepted completion is sent as four frames in consecutive slots. Frame k carries `loc_data[144k+143:144k]`, type 01 and sequence k.
- R7: Forwarded frames leave bit-for-bit unchanged and in arrival order, in the slot after the slot in which they are selected.
- R8: At a slot boundary, a queued forwarded frame goes before a completion that is waiting to start.
- R9: A burst of four local frames is never split. Forwarded frames that arrive during it wait in the queue. A frame or completion accepted in the last cycle of a slot is not eligible for the very next slot.
- R10: `loc_ready` falls the cycle after a completion is accepted. It stays low until the slot that carries that completion's fourth frame, and it is high during that slot.
- R11: The forwarded queue holds 4 frames. With at most one forwarded frame offered per 12 cycles, it never overflows, even during a full local burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit-interval clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_valid | input | 1 | Local completion offered |
| loc_ready | output | 1 | Completion buffer free; accept when both are high |
| loc_data | input | 576 | Completion: four 144-bit payloads, lowest first |
| fwd_valid | input | 1 | Forwarded frame offered (one cycle, at most one per 12 cycles) |
| fwd_frame | input | 168 | Complete frame from the downstream module |
| nb_lanes | output | 14 | Lane bits for the current unit interval |
| slot_start | output | 1 | High in the first unit interval of each slot |

## Verification
The sharpest overlap is a forwarded frame and a local completion both landing in the decision cycle, the last unit interval of a slot. The queue push, the completion capture and the slot selection then all happen in the same clock. The bench drives both inputs at exactly that cycle. It expects an idle slot next, then the forwarded frame, then the four local frames. A second overlap has forwarded frames arriving while a burst owns the output. There the bench expects the burst to stay intact, with all four waiting frames following in order once the queue has filled to its depth.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
    localparam int LANES      = 14;
    localparam int UIS        = 12;
    localparam int PAY_W      = 144;
    localparam int KIND_W     = 2;
    localparam int CPL_FRAMES = 4;
    localparam int IDX_W      = $clog2(CPL_FRAMES);
    localparam int FRAME_W    = LANES * UIS;
    localparam int BODY_W     = PAY_W + KIND_W + IDX_W;
    localparam int CHK_W      = FRAME_W - BODY_W;
    localparam int CPL_W      = PAY_W * CPL_FRAMES;
    localparam int UI_W       = $clog2(UIS);

    typedef enum logic [KIND_W-1:0] {
        KIND_IDLE  = 2'b00,
        KIND_LOCAL = 2'b01
    } frame_kind_e;
endpackage

// File: rtl/nbf_frame_pack.sv
module nbf_frame_pack
    import nbf_pkg::*;
(
    input  logic [PAY_W-1:0]   payload,
    input  frame_kind_e        kind,
    input  logic [IDX_W-1:0]   seq,
    output logic [FRAME_W-1:0] frame
);
    logic [BODY_W-1:0] body;
    logic [CHK_W-1:0]  chk;

    assign body = {kind, seq, payload};

    // check bit j folds every body bit whose index is j modulo CHK_W
    always_comb begin
        chk = '0;
        for (int i = 0; i < BODY_W; i++) begin
            chk[i % CHK_W] = chk[i % CHK_W] ^ body[i];
        end
    end

    assign frame = {chk, body};
endmodule

// File: rtl/nbf_fwd_fifo.sv
module nbf_fwd_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 168
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fq_t;

    fq_t  q_q, q_d;
    logic push_ok, pop_ok;

    assign empty   = (q_q.cnt == '0);
    assign full    = (q_q.cnt == CNT_FULL);
    assign dout    = q_q.mem[q_q.rd];
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);

    always_comb begin
        q_d = q_q;
        if (push_ok) begin
            q_d.mem[q_q.wr] = din;
            q_d.wr = (q_q.wr == PTR_LAST) ? '0 : q_q.wr + PW'(1);
        end
        if (pop_ok) begin
            q_d.rd = (q_q.rd == PTR_LAST) ? '0 : q_q.rd + PW'(1);
        end
        q_d.cnt = q_q.cnt + (push_ok ? CW'(1) : '0) - (pop_ok ? CW'(1) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    // R11: a push into a full queue must coincide with a pop
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);
    // R11: the selector never pops an empty queue
    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/nbf_lane_tap.sv
module nbf_lane_tap
    import nbf_pkg::*;
(
    input  logic [FRAME_W-1:0] frame,
    input  logic [UI_W-1:0]    ui,
    output logic [LANES-1:0]   lanes
);
    always_comb begin
        lanes = '0;
        for (int u = 0; u < UIS; u++) begin
            if (ui == UI_W'(u)) lanes = frame[u*LANES +: LANES];
        end
    end
endmodule

// File: rtl/nb_frame_mux.sv
module nb_frame_mux
    import nbf_pkg::*;
#(
    parameter int FWD_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loc_valid,
    output logic               loc_ready,
    input  logic [CPL_W-1:0]   loc_data,
    input  logic               fwd_valid,
    input  logic [FRAME_W-1:0] fwd_frame,
    output logic [LANES-1:0]   nb_lanes,
    output logic               slot_start
);
    localparam logic [UI_W-1:0]  UI_LAST  = UI_W'(UIS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CPL_FRAMES - 1);

    typedef struct packed {
        logic [UI_W-1:0]    ui;
        logic [FRAME_W-1:0] frame;
        logic               held;
        logic               active;
        logic [IDX_W-1:0]   idx;
        logic [CPL_W-1:0]   cpl;
    } mux_st_t;

    mux_st_t st_q, st_d;

    logic               boundary;
    logic               fq_empty, fq_full, fq_pop;
    logic [FRAME_W-1:0] fq_dout;
    logic [IDX_W-1:0]   sel_idx;
    logic [PAY_W-1:0]   sel_pay;
    logic [FRAME_W-1:0] loc_frame;

    assign boundary   = (st_q.ui == UI_LAST);
    assign slot_start = (st_q.ui == '0);
    assign loc_ready  = !st_q.held;
    assign sel_idx    = st_q.active ? st_q.idx : '0;
    assign sel_pay    = st_q.cpl[int'(sel_idx)*PAY_W +: PAY_W];

    nbf_fwd_fifo #(.DEPTH(FWD_DEPTH), .W(FRAME_W)) u_fwd_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fwd_valid),
        .din   (fwd_frame),
        .pop   (fq_pop),
        .dout  (fq_dout),
        .empty (fq_empty),
        .full  (fq_full)
    );

    nbf_frame_pack u_pack (
        .payload (sel_pay),
        .kind    (KIND_LOCAL),
        .seq     (sel_idx),
        .frame   (loc_frame)
    );

    nbf_lane_tap u_tap (
        .frame (st_q.frame),
        .ui    (st_q.ui),
        .lanes (nb_lanes)
    );

    always_comb begin
        st_d   = st_q;
        fq_pop = 1'b0;
        st_d.ui = boundary ? '0 : st_q.ui + UI_W'(1);

        if (loc_valid && !st_q.held) begin
            st_d.held = 1'b1;
            st_d.cpl  = loc_data;
        end

        if (boundary) begin
            if (st_q.active) begin
                st_d.frame = loc_frame;
                if (st_q.idx == IDX_LAST) begin
                    st_d.active = 1'b0;
                    st_d.held   = 1'b0;
                    st_d.idx    = '0;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                end
            end else if (!fq_empty) begin
                st_d.frame = fq_dout;
                fq_pop     = 1'b1;
            end else if (st_q.held) begin
                st_d.frame  = loc_frame;
                st_d.active = 1'b1;
                st_d.idx    = IDX_W'(1);
            end else begin
                st_d.frame = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a slot start is never followed directly by another
    assert_slot_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> !slot_start);
    // R2: the cycle after the decision cycle opens a new slot
    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> slot_start);
    // R10: accepting a completion closes the buffer at once
    assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && loc_ready) |=> !loc_ready);
    // R9/R10: while a burst is in progress no new completion can enter
    assert_burst_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> !loc_ready);
    // R8: a queued forwarded frame wins an open boundary
    assert_fwd_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !st_q.active && !fq_empty) |=> (st_q.frame == $past(fq_dout)));
    // R5: nothing to send means an all-zero idle frame
    assert_idle_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !st_q.active && fq_empty && !st_q.held) |=> (st_q.frame == '0));
endmodule

// File: tb/tb_nb_frame_mux.sv
module tb_nb_frame_mux;
    import nbf_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               loc_valid;
    logic               loc_ready;
    logic [CPL_W-1:0]   loc_data;
    logic               fwd_valid;
    logic [FRAME_W-1:0] fwd_frame;
    logic [LANES-1:0]   nb_lanes;
    logic               slot_start;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    nb_frame_mux dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .loc_valid  (loc_valid),
        .loc_ready  (loc_ready),
        .loc_data   (loc_data),
        .fwd_valid  (fwd_valid),
        .fwd_frame  (fwd_frame),
        .nb_lanes   (nb_lanes),
        .slot_start (slot_start)
    );

    // stimulus table: {kind, seed}; kind 0 = idle slot, 1 = local completion, 2 = forwarded frame
    localparam logic [33:0] VEC [6] = '{
        {2'd0, 32'h0000_0000},
        {2'd1, 32'hA5A5_0001},
        {2'd2, 32'h1234_5678},
        {2'd1, 32'h0F0F_F0F0},
        {2'd2, 32'hDEAD_BEEF},
        {2'd0, 32'h0000_0000}
    };

    task automatic check(input bit ok, input string req,
                         input logic [FRAME_W-1:0] got, input logic [FRAME_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [FRAME_W-1:0] mk_frame(input logic [PAY_W-1:0] pay,
                                                   input logic [1:0] kind,
                                                   input logic [1:0] seq);
        logic [FRAME_W-1:0] f;
        f = '0;
        f[PAY_W-1:0]     = pay;
        f[PAY_W+1:PAY_W] = seq;
        f[PAY_W+3:PAY_W+2] = kind;
        for (int i = 0; i < PAY_W + 4; i++) f[PAY_W + 4 + (i % 20)] ^= f[i];
        return f;
    endfunction

    function automatic logic [CPL_W-1:0] gen_cpl(input logic [31:0] seed);
        logic [CPL_W-1:0] r;
        for (int w = 0; w < CPL_W / 32; w++) r[w*32 +: 32] = seed ^ (32'(w) * 32'h9E37_79B9);
        return r;
    endfunction

    function automatic logic [FRAME_W-1:0] gen_fwd(input logic [31:0] seed);
        logic [FRAME_W-1:0] r;
        for (int w = 0; w < FRAME_W / 8; w++) r[w*8 +: 8] = seed[7:0] ^ seed[23:16] ^ 8'(w * 37 + 1);
        return r;
    endfunction

    function automatic logic [FRAME_W-1:0] loc_exp(input logic [CPL_W-1:0] d, input int k);
        return mk_frame(d[k*PAY_W +: PAY_W], 2'b01, 2'(k));
    endfunction

    // collect one slot; optional drive in its first unit interval
    task automatic run_slot(input bit df, input logic [FRAME_W-1:0] ff,
                            input bit dl, input logic [CPL_W-1:0] ld,
                            output logic [FRAME_W-1:0] got, output logic rdy0,
                            output logic [LANES-1:0] first);
        do @(negedge clk); while (!slot_start);
        got = '0;
        first = nb_lanes;
        rdy0 = loc_ready;
        got[LANES-1:0] = nb_lanes;
        fwd_valid = df; fwd_frame = ff; loc_valid = dl; loc_data = ld;
        @(posedge clk);
        #1 fwd_valid = 1'b0; loc_valid = 1'b0;
        for (int u = 1; u < UIS; u++) begin
            @(negedge clk);
            got[u*LANES +: LANES] = nb_lanes;
        end
    endtask

    task automatic expect_slot(input logic [FRAME_W-1:0] exp, input string req);
        logic [FRAME_W-1:0] g; logic r; logic [LANES-1:0] f0;
        run_slot(1'b0, '0, 1'b0, '0, g, r, f0);
        check(g == exp, req, g, exp);
    endtask

    task automatic expect_burst(input logic [CPL_W-1:0] d, input string req);
        logic [FRAME_W-1:0] g; logic r; logic [LANES-1:0] f0;
        for (int k = 0; k < CPL_FRAMES; k++) begin
            run_slot(1'b0, '0, 1'b0, '0, g, r, f0);
            check(g == loc_exp(d, k), req, g, loc_exp(d, k));
            // R10: ready only returns in the slot that carries the fourth frame
            check(r == (k == CPL_FRAMES - 1), "R10 ready during burst", FRAME_W'(r),
                  FRAME_W'(k == CPL_FRAMES - 1));
        end
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_err++;
            $display("FAIL R2 watchdog got=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [FRAME_W-1:0] g;
        logic               r;
        logic [LANES-1:0]   f0;
        logic [CPL_W-1:0]   la, lb, lc;
        logic [FRAME_W-1:0] fa, fb;

        rst_n = 1'b0; loc_valid = 1'b0; loc_data = '0; fwd_valid = 1'b0; fwd_frame = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(slot_start == 1'b1, "R1 slot_start in reset", FRAME_W'(slot_start), FRAME_W'(1));
        check(nb_lanes == '0, "R1 idle lanes in reset", FRAME_W'(nb_lanes), '0);
        check(loc_ready == 1'b1, "R1 ready in reset", FRAME_W'(loc_ready), FRAME_W'(1));
        rst_n = 1'b1;
        expect_slot('0, "R1 first slot idle");

        // table-driven pass
        for (int v = 0; v < 6; v++) begin
            case (VEC[v][33:32])
                2'd0: expect_slot('0, "R5 idle slot");
                2'd1: begin
                    la = gen_cpl(VEC[v][31:0]);
                    run_slot(1'b0, '0, 1'b1, la, g, r, f0);
                    check(r == 1'b1, "R10 ready before accept", FRAME_W'(r), FRAME_W'(1));
                    check(g == '0, "R5 slot during accept", g, '0);
                    expect_burst(la, "R6 local frame");
                end
                default: begin
                    fa = gen_fwd(VEC[v][31:0]);
                    run_slot(1'b1, fa, 1'b0, '0, g, r, f0);
                    check(g == '0, "R5 slot during push", g, '0);
                    run_slot(1'b0, '0, 1'b0, '0, g, r, f0);
                    check(g == fa, "R7 forwarded frame", g, fa);
                    // R3: lane 0 of the first unit interval carries frame bit 0
                    check(f0 == fa[LANES-1:0], "R3 lane map", FRAME_W'(f0), FRAME_W'(fa[LANES-1:0]));
                end
            endcase
        end

        // R4: explicit tag and check field on a local frame
        lb = gen_cpl(32'h5555_AAAA);
        run_slot(1'b0, '0, 1'b1, lb, g, r, f0);
        run_slot(1'b0, '0, 1'b0, '0, g, r, f0);
        check(g[147:144] == 4'b0100, "R4 tag of frame 0", FRAME_W'(g[147:144]), FRAME_W'(4'b0100));
        check(g == loc_exp(lb, 0), "R4 check field", g, loc_exp(lb, 0));
        for (int k = 1; k < CPL_FRAMES; k++) expect_slot(loc_exp(lb, k), "R6 remaining frames");

        // R8: both offered in the same slot; forwarded goes first
        fa = gen_fwd(32'h0BAD_F00D);
        lc = gen_cpl(32'h7777_1111);
        run_slot(1'b1, fa, 1'b1, lc, g, r, f0);
        expect_slot(fa, "R8 forwarded before local");
        expect_burst(lc, "R8 local after forwarded");

        // R9: forwarded arrival during a burst waits until it ends
        la = gen_cpl(32'h2468_ACE0);
        fb = gen_fwd(32'h1357_9BDF);
        run_slot(1'b0, '0, 1'b1, la, g, r, f0);
        run_slot(1'b1, fb, 1'b0, '0, g, r, f0);
        check(g == loc_exp(la, 0), "R9 burst frame 0", g, loc_exp(la, 0));
        for (int k = 1; k < CPL_FRAMES; k++) expect_slot(loc_exp(la, k), "R9 burst not split");
        expect_slot(fb, "R9 forwarded after burst");

        // R11: four forwarded arrivals during one burst fill the queue
        lb = gen_cpl(32'hC0DE_0004);
        run_slot(1'b0, '0, 1'b1, lb, g, r, f0);
        for (int k = 0; k < CPL_FRAMES; k++) begin
            run_slot(1'b1, gen_fwd(32'h100 + 32'(k)), 1'b0, '0, g, r, f0);
            check(g == loc_exp(lb, k), "R11 burst while filling", g, loc_exp(lb, k));
        end
        for (int k = 0; k < 4; k++) expect_slot(gen_fwd(32'h100 + 32'(k)), "R11 queued order");

        // R9: both arrive in the decision cycle; neither may take the next slot
        lc = gen_cpl(32'hFACE_0099);
        fa = gen_fwd(32'h0000_0E0E);
        fwd_valid = 1'b1; fwd_frame = fa; loc_valid = 1'b1; loc_data = lc;
        @(posedge clk);
        #1 fwd_valid = 1'b0; loc_valid = 1'b0;
        expect_slot('0, "R9 late arrivals not eligible");
        expect_slot(fa, "R9 late forwarded next");
        expect_burst(lc, "R9 late local after");
        expect_slot('0, "R5 idle after all traffic");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule